// File: doc/BRIEF.md
# Selectable-Sequence Binary Correlator

This block correlates a stream of signed two's-complement samples against one of several stored one-bit coefficient patterns. Each pattern weights every sample in a sliding window by +1 or -1 and adds the results. Every sample arrives with a pattern select, so consecutive samples can be scored against different patterns. The window covers the accepted sample and the NUM_TAP-1 samples accepted before it. The older samples sit in an internal tap history.

Software or a loader state machine fills the coefficient store before any sample is sent. Each write places one row of MWIDTH coefficient bits. A pattern of NUM_TAP bits takes NUM_TAP/MWIDTH consecutive rows, and the patterns are stacked one after another. Each accepted sample yields exactly one signed sum, a fixed LATENCY clock edges later. The sum is wide enough that it never overflows.

Top module: `binary_correlator`

## Requirements
- R1: On a rising clock edge with `cfg_we` high and `cfg_row` below NUM_TAP*NUM_COEF_SEQ/MWIDTH (12 by default), `cfg_data` is stored in that row. Writes to higher row numbers change no stored row.
- R2: Bit b of pattern s is held in row s*(NUM_TAP/MWIDTH) + b/MWIDTH, at bit position b mod MWIDTH of that row.
- R3: Pattern bit 0 weights the sample being accepted (the newest). Pattern bit k weights the sample accepted k samples earlier. Bit NUM_TAP-1 therefore weights the oldest sample in the window.
- R4: A coefficient bit of 1 adds the sample as a two's-complement value. A bit of 0 subtracts it.
- R5: `samp_sel` chooses the pattern for its own sample. A value of NUM_COEF_SEQ or more selects pattern 0.
- R6: A synchronous reset fills the tap history with zeros and leaves the coefficient store unchanged.
- R7: `sum_valid` goes high exactly LATENCY rising edges after an accepting edge, counting that edge as the first, and it carries that sample's sum. There is one result per accepted sample, and `sum_valid` is low in every other cycle.
- R8: `sum_out` is SAMP_W+clog2(NUM_TAP)+1 bits wide (13 by default). Full-scale inputs such as sixteen samples of -128 give exact results of -2048 and +2048.
- R9: The tap history moves only on edges where `samp_valid` is high. Idle cycles do not shift it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset of history and output pipeline |
| cfg_we | input | 1 | Coefficient row write enable |
| cfg_row | input | ROW_AW (4) | Coefficient row address |
| cfg_data | input | MWIDTH (4) | Coefficient row contents |
| samp_valid | input | 1 | Sample accepted on this edge |
| samp_data | input | SAMP_W (8) | Signed sample |
| samp_sel | input | SEL_W (2) | Pattern select for this sample |
| sum_valid | output | 1 | Result strobe |
| sum_out | output | SUM_W (13) | Signed correlation sum |

## Verification
A sample presented before a rising edge with `samp_valid` high is due on `sum_out` right after the LATENCY-th rising edge, counting that edge as the first (the second edge by default). The bench mirrors this with its own LATENCY-deep queue of expected strobes and sums, shifted once per edge. It compares outputs on the falling edge that follows each rising edge, and it checks the strobe in every cycle, so an early, late, missing or extra result is reported. Coefficient writes take effect on their own edge, and the bench never sends a sample in the same cycle as a write.

// File: rtl/corr_pkg.sv
package corr_pkg;
  // Weight one sample by a coefficient bit: 1 -> +sample, 0 -> -sample.
  function automatic int weigh(input int s, input logic c);
    return c ? s : -s;
  endfunction

  // Sum width that holds NUM_TAP full-scale samples without overflow.
  function automatic int sum_width(input int samp_w, input int taps);
    return samp_w + $clog2(taps) + 1;
  endfunction
endpackage

// File: rtl/corr_coef_mem.sv
module corr_coef_mem #(
  parameter int MWIDTH = 4,
  parameter int ROWS   = 12,
  parameter int ROW_AW = 4
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [ROW_AW-1:0]        row,
  input  logic [MWIDTH-1:0]        wdata,
  output logic                     wr_hit,
  output logic [ROWS*MWIDTH-1:0]   rows_flat
);
  logic [MWIDTH-1:0] mem [ROWS];

  assign wr_hit = we && (int'(row) < ROWS);

  always_ff @(posedge clk) begin
    if (wr_hit) mem[row] <= wdata;
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_pack
    assign rows_flat[r*MWIDTH +: MWIDTH] = mem[r];
  end
endmodule

// File: rtl/corr_tap_line.sv
module corr_tap_line #(
  parameter int SAMP_W = 8,
  parameter int DEPTH  = 15
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     shift,
  input  logic [SAMP_W-1:0]        din,
  output logic [DEPTH*SAMP_W-1:0]  taps_flat
);
  logic [SAMP_W-1:0] taps [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) taps[i] <= '0;
    end else if (shift) begin
      taps[0] <= din;
      for (int i = 1; i < DEPTH; i++) taps[i] <= taps[i-1];
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_pack
    assign taps_flat[i*SAMP_W +: SAMP_W] = taps[i];
  end
endmodule

// File: rtl/corr_dot.sv
module corr_dot #(
  parameter int SAMP_W  = 8,
  parameter int NUM_TAP = 16,
  parameter int SUM_W   = 13
) (
  input  logic [NUM_TAP*SAMP_W-1:0] window,
  input  logic [NUM_TAP-1:0]        pattern,
  output logic [SUM_W-1:0]          sum
);
  import corr_pkg::*;
  int acc;

  always_comb begin
    acc = 0;
    for (int b = 0; b < NUM_TAP; b++)
      acc = acc + weigh(int'($signed(window[b*SAMP_W +: SAMP_W])), pattern[b]);
  end

  assign sum = SUM_W'(acc);
endmodule

// File: rtl/corr_delay.sv
module corr_delay #(
  parameter int WIDTH   = 13,
  parameter int LATENCY = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_v,
  input  logic [WIDTH-1:0] in_d,
  output logic             out_v,
  output logic [WIDTH-1:0] out_d
);
  logic             st_v [LATENCY];
  logic [WIDTH-1:0] st_d [LATENCY];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LATENCY; i++) begin
        st_v[i] <= 1'b0;
        st_d[i] <= '0;
      end
    end else begin
      st_v[0] <= in_v;
      st_d[0] <= in_d;
      for (int i = 1; i < LATENCY; i++) begin
        st_v[i] <= st_v[i-1];
        st_d[i] <= st_d[i-1];
      end
    end
  end

  assign out_v = st_v[LATENCY-1];
  assign out_d = st_d[LATENCY-1];
endmodule

// File: rtl/binary_correlator.sv
module binary_correlator #(
  parameter int SAMP_W       = 8,
  parameter int NUM_TAP      = 16,
  parameter int MWIDTH       = 4,
  parameter int NUM_COEF_SEQ = 3,
  parameter int LATENCY      = 2,
  localparam int ROWS_PER_SEQ = NUM_TAP / MWIDTH,
  localparam int ROWS         = ROWS_PER_SEQ * NUM_COEF_SEQ,
  localparam int ROW_AW       = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int SEL_W        = $clog2(NUM_COEF_SEQ + 1),
  localparam int SUM_W        = corr_pkg::sum_width(SAMP_W, NUM_TAP)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [ROW_AW-1:0] cfg_row,
  input  logic [MWIDTH-1:0] cfg_data,
  input  logic              samp_valid,
  input  logic [SAMP_W-1:0] samp_data,
  input  logic [SEL_W-1:0]  samp_sel,
  output logic              sum_valid,
  output logic [SUM_W-1:0]  sum_out
);
  logic                            wr_hit;
  logic [ROWS*MWIDTH-1:0]          rows_flat;
  logic [(NUM_TAP-1)*SAMP_W-1:0]   taps_flat;
  logic [NUM_TAP*SAMP_W-1:0]       window;
  logic [NUM_TAP-1:0]              pattern;
  logic [NUM_TAP-1:0]              pat_by_seq [NUM_COEF_SEQ];
  logic                            sel_ok;
  logic [SUM_W-1:0]                dot_sum;
  logic [SAMP_W-1:0]               hist_newest;

  corr_coef_mem #(.MWIDTH(MWIDTH), .ROWS(ROWS), .ROW_AW(ROW_AW)) u_mem (
    .clk(clk), .we(cfg_we), .row(cfg_row), .wdata(cfg_data),
    .wr_hit(wr_hit), .rows_flat(rows_flat)
  );

  corr_tap_line #(.SAMP_W(SAMP_W), .DEPTH(NUM_TAP-1)) u_taps (
    .clk(clk), .rst(rst), .shift(samp_valid), .din(samp_data),
    .taps_flat(taps_flat)
  );

  // Window index 0 is the incoming sample, index k the sample k steps older.
  assign window      = {taps_flat, samp_data};
  assign hist_newest = taps_flat[SAMP_W-1:0];

  // Patterns are contiguous in the row store, bit 0 in the low bit of the first row.
  for (genvar s = 0; s < NUM_COEF_SEQ; s++) begin : g_seq
    assign pat_by_seq[s] = rows_flat[s*NUM_TAP +: NUM_TAP];
  end

  assign sel_ok  = int'(samp_sel) < NUM_COEF_SEQ;
  assign pattern = sel_ok ? pat_by_seq[samp_sel] : pat_by_seq[0];

  corr_dot #(.SAMP_W(SAMP_W), .NUM_TAP(NUM_TAP), .SUM_W(SUM_W)) u_dot (
    .window(window), .pattern(pattern), .sum(dot_sum)
  );

  corr_delay #(.WIDTH(SUM_W), .LATENCY(LATENCY)) u_dly (
    .clk(clk), .rst(rst), .in_v(samp_valid), .in_d(dot_sum),
    .out_v(sum_valid), .out_d(sum_out)
  );
endmodule

// File: rtl/corr_checker.sv
module corr_checker #(
  parameter int SAMP_W  = 8,
  parameter int NUM_TAP = 16,
  parameter int ROWS    = 12,
  parameter int ROW_AW  = 4,
  parameter int SUM_W   = 13,
  parameter int LATENCY = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_we,
  input logic [ROW_AW-1:0] cfg_row,
  input logic              wr_hit,
  input logic              samp_valid,
  input logic [SAMP_W-1:0] samp_data,
  input logic [SAMP_W-1:0] hist_newest,
  input logic              sum_valid,
  input logic [SUM_W-1:0]  sum_out
);
  localparam int LIMIT = NUM_TAP * (1 << (SAMP_W - 1));
  int pending;

  always_ff @(posedge clk) begin
    if (rst) pending <= 0;
    else pending <= pending + (samp_valid ? 1 : 0) - (sum_valid ? 1 : 0);
  end

  // R1
  row_guard_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && int'(cfg_row) >= ROWS) |-> !wr_hit);

  // R9
  shift_in_chk: assert property (@(posedge clk) disable iff (rst)
    samp_valid |=> hist_newest == $past(samp_data));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !samp_valid |=> $stable(hist_newest));

  // R7
  strobe_owed_chk: assert property (@(posedge clk) disable iff (rst)
    sum_valid |-> pending > 0);

  // R7
  pending_bound_chk: assert property (@(posedge clk) disable iff (rst)
    pending <= LATENCY);

  // R6
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> !sum_valid);

  // R8
  range_chk: assert property (@(posedge clk) disable iff (rst)
    sum_valid |-> ($signed(sum_out) <= LIMIT && $signed(sum_out) >= -LIMIT));
endmodule

bind binary_correlator corr_checker #(
  .SAMP_W(SAMP_W), .NUM_TAP(NUM_TAP), .ROWS(ROWS), .ROW_AW(ROW_AW),
  .SUM_W(SUM_W), .LATENCY(LATENCY)
) u_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_row(cfg_row), .wr_hit(wr_hit),
  .samp_valid(samp_valid), .samp_data(samp_data), .hist_newest(hist_newest),
  .sum_valid(sum_valid), .sum_out(sum_out)
);

// File: tb/sim_binary_correlator.sv
module sim_binary_correlator;
  localparam int SW = 8, NT = 16, MW = 4, NS = 3, LAT = 2;
  localparam int RPS = NT / MW, ROWS = RPS * NS, AW = 4, SELW = 2;
  localparam int SUMW = SW + $clog2(NT) + 1;

  logic clk = 0, rst = 1, cfg_we = 0, samp_valid = 0;
  logic [AW-1:0] cfg_row = '0;
  logic [MW-1:0] cfg_data = '0;
  logic [SW-1:0] samp_data = '0;
  logic [SELW-1:0] samp_sel = '0;
  logic sum_valid;
  logic [SUMW-1:0] sum_out;

  always #2 clk = ~clk;

  binary_correlator #(.SAMP_W(SW), .NUM_TAP(NT), .MWIDTH(MW),
    .NUM_COEF_SEQ(NS), .LATENCY(LAT)) u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_row(cfg_row), .cfg_data(cfg_data),
    .samp_valid(samp_valid), .samp_data(samp_data), .samp_sel(samp_sel),
    .sum_valid(sum_valid), .sum_out(sum_out));

  int checks = 0, fails = 0, cyc = 0;
  string tag = "R7";
  logic [MW-1:0] m_rows [ROWS];
  int m_hist [NT];
  logic m_pv [LAT];
  logic [SUMW-1:0] m_ps [LAT];

  function automatic int ref_sum(int newest, int sel);
    int acc = 0, s;
    int q = (sel < NS) ? sel : 0;
    for (int b = 0; b < NT; b++) begin
      logic c = m_rows[q*RPS + b/MW][b%MW];
      s = (b == 0) ? newest : m_hist[b-1];
      acc += c ? s : -s;
    end
    return acc;
  endfunction

  task automatic step(input logic we, input int row, input logic [MW-1:0] wd,
                      input logic v, input int d, input int sel, input logic r);
    int e;
    cfg_we = we; cfg_row = AW'(row); cfg_data = wd;
    samp_valid = v; samp_data = SW'(d); samp_sel = SELW'(sel); rst = r;
    @(posedge clk);
    if (r) begin
      for (int i = 0; i < NT; i++) m_hist[i] = 0;
      for (int i = 0; i < LAT; i++) begin m_pv[i] = 0; m_ps[i] = '0; end
    end else begin
      e = v ? ref_sum(int'($signed(SW'(d))), sel) : 0;
      for (int i = LAT-1; i > 0; i--) begin m_pv[i] = m_pv[i-1]; m_ps[i] = m_ps[i-1]; end
      m_pv[0] = v; m_ps[0] = SUMW'(e);
      if (v) begin
        for (int i = NT-1; i > 0; i--) m_hist[i] = m_hist[i-1];
        m_hist[0] = int'($signed(SW'(d)));
      end
    end
    if (we && row < ROWS) m_rows[row] = wd;
    @(negedge clk);
    cyc++;
    checks++;
    if (sum_valid !== m_pv[LAT-1]) begin
      fails++;
      $display("FAIL R7 sum_valid actual=%0b expected=%0b", sum_valid, m_pv[LAT-1]);
    end else if (m_pv[LAT-1]) begin
      checks++;
      if (sum_out !== m_ps[LAT-1]) begin
        fails++;
        $display("FAIL %s sum_out actual=%0d expected=%0d", tag,
                 $signed(sum_out), $signed(m_ps[LAT-1]));
      end
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, '0, 0, 0, 0, 0);
  endtask

  task automatic load(int s, logic [NT-1:0] pat);
    for (int j = 0; j < RPS; j++) step(1, s*RPS + j, pat[j*MW +: MW], 0, 0, 0, 0);
  endtask

  initial begin
    for (int i = 0; i < ROWS; i++) m_rows[i] = '0;
    step(0, 0, '0, 0, 0, 0, 1);
    step(0, 0, '0, 0, 0, 0, 1);
    tag = "R6"; idle(2);                 // R6: no result after reset
    // R1 R2: load three patterns, then an out-of-range row write
    tag = "R2";
    load(0, 16'hA6FC); load(1, 16'h0180); load(2, 16'h3C5A);
    step(1, 13, 4'hF, 0, 0, 0, 0);
    step(1, 15, 4'h0, 0, 0, 0, 0);
    // R3 R4: impulse walks through the window; each position tests one bit
    tag = "R3";
    step(0, 0, '0, 1, 100, 0, 0);
    for (int k = 1; k < NT + 2; k++) step(0, 0, '0, 1, 0, k % 3, 0);
    idle(LAT);
    // R9: gaps between samples must not shift history
    tag = "R9";
    step(0, 0, '0, 1, -37, 1, 0); idle(3);
    step(0, 0, '0, 1, 55, 2, 0);  idle(2);
    step(0, 0, '0, 1, 9, 0, 0);   idle(LAT);
    // R5: out-of-range select uses pattern 0
    tag = "R5";
    for (int k = 0; k < 6; k++) step(0, 0, '0, 1, 20*k - 50, 3, 0);
    idle(LAT);
    // R8: full-scale extremes
    tag = "R8";
    load(2, 16'hFFFF);
    for (int k = 0; k < NT; k++) step(0, 0, '0, 1, -128, 2, 0);
    load(2, 16'h0000);
    step(0, 0, '0, 1, -128, 2, 0);
    idle(LAT);
    // R6: reset clears history but keeps coefficients
    tag = "R6";
    step(0, 0, '0, 0, 0, 0, 1);
    step(0, 0, '0, 1, 77, 1, 0);
    step(0, 0, '0, 1, -5, 0, 0);
    idle(LAT);
    // R4 R5 R7: constrained random mix
    tag = "R4";
    void'($urandom(32'h5eed));
    for (int k = 0; k < 600; k++) begin
      int sel = $urandom_range(0, 3);
      int d = $urandom_range(0, 255);
      logic v = ($urandom_range(0, 9) < 7);
      if (k % 150 == 149) begin
        tag = "R1";
        load(k % NS, NT'($urandom));
        tag = "R4";
      end else step(0, 0, '0, v, d, sel, 0);
    end
    idle(LAT + 1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    fails++;
    $display("FAIL R7 watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule